// File: doc/BRIEF.md
# Rotating-window register file

This block is a register file for a processor whose procedures each see their own set of 32 registers. A procedure call moves a current-window pointer one step forward and a return moves it back. Each logical register number on the three ports is translated through that pointer into a slot of a flat physical array. A small group of registers is the same in every window. Each window also has a private group of its own, and it shares one group with each of its neighbours. The top six registers of a caller are the same physical storage as registers 10 to 15 of its callee, so parameters and results pass between them without any copy.

The block has two combinational read ports and one write port that stores on the clock edge. It also tracks how many windows are nested and in use. When a call goes past the deepest window that still fits, or a return goes below the oldest window still held, it raises a flag in the same cycle. The pointer still moves in both cases and the count saturates. Writing the displaced window out to memory, and reading it back, is left to the code around the block. With the default sizes the physical array holds 10 + 16 × 8 = 138 words of 32 bits.

Top module: `rwin_regfile`

## Requirements
- R1: A synchronous reset sets the window pointer to 0 and the nesting count to 0, so a return issued right after reset raises the underflow flag. Register contents are kept through reset.
- R2: Logical register 0 reads as all zeros on both read ports, and a write to it is ignored.
- R3: Logical registers 1 to 9 are global: a value written in one window is read back unchanged in every other window.
- R4: Logical registers 26+j of window k (outgoing, j = 0..5) are the same storage as logical registers 10+j of window k+1 (incoming).
- R5: Logical registers 16 to 25 are private to each window. A write to one of them in window k+1 leaves the register with the same number in window k unchanged.
- R6: A call pulse (call high, return low) moves the pointer to (cwp+1) mod W on the next clock edge. A return pulse (return high, call low) moves it to (cwp−1) mod W. The pointer is visible on `cwp_o`.
- R7: A call with the nesting count at W−1 raises `ovf_o` in that same cycle. The pointer still advances and the count stays at W−1.
- R8: A return with the nesting count at 0 raises `unf_o` in that same cycle. The pointer still moves back and the count stays at 0.
- R9: When call and return are high in the same cycle, the pointer and the count do not change and neither flag is raised.
- R10: A read of the physical register that is being written in the same cycle returns the new write data (write-first).
- R11: Each read port returns, combinationally, the last value written to the physical register its address maps to. A write takes effect at the clock edge, and the mapping uses the pointer as it stands before any call or return in that cycle.
- R12: The window ring wraps: the outgoing registers of window W−1 are the incoming registers of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Procedure call: advance the window |
| ret_i | input | 1 | Procedure return: retreat the window |
| rd_a_addr_i | input | 5 | Logical register number for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Logical register number for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register number for the write |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Window overflow on this call |
| unf_o | output | 1 | Window underflow on this return |

## Verification
Read data and both flags are combinational, so they are due in the same cycle as the addresses and the call or return that produce them. A write shows up on the read ports in that same cycle only through the write-first path; otherwise it appears after the next rising edge, and a pointer change shows up one edge after the pulse. The bench drives every input at the falling edge and compares the outputs one nanosecond later, well before the rising edge. Its reference model then applies the write and the pointer update at the rising edge, so each expected value belongs to exactly one cycle.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
   // width of a logical register number on every port
   localparam int LREG_W = 5;
   // number of logical registers one procedure sees
   localparam int LREG_N = 1 << LREG_W;

   // width able to hold values 0..n-1 (at least one bit)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rwin_map.sv
// Translates a logical register number into a physical slot.
module rwin_map
   import rwin_pkg::*;
#(
   parameter int N_GLOB  = 10,
   parameter int N_LOCAL = 10,
   parameter int N_SHARE = 6,
   parameter int N_WIN   = 8,
   parameter int CW_W    = idx_w(N_WIN),
   parameter int PH_W    = idx_w(N_GLOB + (N_LOCAL + N_SHARE) * N_WIN)
) (
   input  logic [CW_W-1:0]   cwp_i,
   input  logic [LREG_W-1:0] lreg_i,
   output logic [PH_W-1:0]   preg_o
);
   localparam int STRIDE   = N_LOCAL + N_SHARE;     // slots one window owns
   localparam int RING     = STRIDE * N_WIN;        // windowed slots in total
   localparam int OUT_BASE = N_GLOB + N_SHARE + N_LOCAL;

   int unsigned lr_v;
   int unsigned off_v;
   int unsigned sum_v;
   int unsigned ring_v;

   always_comb begin
      lr_v   = int'(lreg_i);
      off_v  = 0;
      sum_v  = 0;
      ring_v = 0;
      if (lr_v < N_GLOB) begin
         preg_o = PH_W'(lr_v);
      end else begin
         if (lr_v < OUT_BASE)
            off_v = lr_v - N_GLOB;                  // incoming + local
         else
            off_v = lr_v - OUT_BASE + STRIDE;       // next window's incoming
         sum_v  = int'(cwp_i) * STRIDE + off_v;
         // sum stays below 2*RING, so one conditional subtract is a full modulo
         ring_v = (sum_v >= RING) ? sum_v - RING : sum_v;
         preg_o = PH_W'(N_GLOB + ring_v);
      end
   end
endmodule

// File: rtl/rwin_ctrl.sv
// Window pointer and nesting-depth tracking.
module rwin_ctrl
   import rwin_pkg::*;
#(
   parameter int N_WIN = 8,
   parameter int CW_W  = idx_w(N_WIN)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            call_i,
   input  logic            ret_i,
   output logic [CW_W-1:0] cwp_o,
   output logic            ovf_o,
   output logic            unf_o
);
   localparam logic [CW_W-1:0] TOP = CW_W'(N_WIN - 1);

   logic [CW_W-1:0] cwp_q;
   logic [CW_W-1:0] depth_q;
   logic            do_call;
   logic            do_ret;

   assign do_call = call_i & ~ret_i;
   assign do_ret  = ret_i & ~call_i;
   assign ovf_o   = do_call && (depth_q == TOP);
   assign unf_o   = do_ret && (depth_q == '0);
   assign cwp_o   = cwp_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cwp_q   <= '0;
         depth_q <= '0;
      end else if (do_call) begin
         cwp_q <= (cwp_q == TOP) ? '0 : cwp_q + 1'b1;
         if (depth_q != TOP) depth_q <= depth_q + 1'b1;
      end else if (do_ret) begin
         cwp_q <= (cwp_q == '0) ? TOP : cwp_q - 1'b1;
         if (depth_q != '0) depth_q <= depth_q - 1'b1;
      end
   end

   p_call_adv_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (call_i && !ret_i) |=> (int'(cwp_o) == (int'($past(cwp_o)) + 1) % N_WIN));
   p_ret_back_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (ret_i && !call_i) |=> (int'(cwp_o) == (int'($past(cwp_o)) + N_WIN - 1) % N_WIN));
   p_both_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (call_i && ret_i) |=> ($stable(cwp_o) && $stable(depth_q)));
   p_ovf_sat_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      ovf_o |=> (depth_q == TOP));
   p_unf_sat_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      unf_o |=> (depth_q == '0));
   p_flag_excl_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !(ovf_o && unf_o));
endmodule

// File: rtl/rwin_store.sv
// Flat physical array: one write port, NRD combinational read ports.
module rwin_store
   import rwin_pkg::*;
#(
   parameter int  DW          = 32,
   parameter int  NPHYS       = 138,
   parameter int  NRD         = 2,
   parameter bit  WRITE_FIRST = 1'b1,
   parameter int  PH_W        = idx_w(NPHYS)
) (
   input  logic                  clk_i,
   input  logic                  we_i,
   input  logic [PH_W-1:0]       widx_i,
   input  logic [DW-1:0]         wdata_i,
   input  logic [NRD-1:0][PH_W-1:0] ridx_i,
   output logic [NRD-1:0][DW-1:0]   rdata_o
);
   logic [DW-1:0] mem_q [NPHYS];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[widx_i] <= wdata_i;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      if (WRITE_FIRST) begin : g_bypass
         assign rdata_o[p] = (we_i && (widx_i == ridx_i[p])) ? wdata_i
                                                             : mem_q[ridx_i[p]];
      end else begin : g_plain
         assign rdata_o[p] = mem_q[ridx_i[p]];
      end
   end
endmodule

// File: rtl/rwin_regfile.sv
// Register file with overlapping per-procedure windows.
module rwin_regfile
   import rwin_pkg::*;
#(
   parameter int DW          = 32,
   parameter int N_GLOB      = 10,
   parameter int N_LOCAL     = 10,
   parameter int N_SHARE     = 6,
   parameter int N_WIN       = 8,
   parameter bit WRITE_FIRST = 1'b1,
   parameter int CW_W        = idx_w(N_WIN)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [LREG_W-1:0] rd_a_addr_i,
   output logic [DW-1:0]     rd_a_data_o,
   input  logic [LREG_W-1:0] rd_b_addr_i,
   output logic [DW-1:0]     rd_b_data_o,
   input  logic              wr_en_i,
   input  logic [LREG_W-1:0] wr_addr_i,
   input  logic [DW-1:0]     wr_data_i,
   output logic [CW_W-1:0]   cwp_o,
   output logic              ovf_o,
   output logic              unf_o
);
   localparam int NPHYS = N_GLOB + (N_LOCAL + N_SHARE) * N_WIN;
   localparam int PH_W  = idx_w(NPHYS);
   localparam int NRD   = 2;
   localparam int NPORT = NRD + 1;   // last one is the write port

   if (N_GLOB + N_LOCAL + 2 * N_SHARE != LREG_N) begin : g_bad_size
      $error("window size must equal the logical register count");
   end
   if (N_WIN < 2) begin : g_bad_win
      $error("at least two windows are required");
   end
   if (N_GLOB < 1) begin : g_bad_glob
      $error("logical register 0 must be a global");
   end

   logic [NPORT-1:0][LREG_W-1:0] lreg;
   logic [NPORT-1:0][PH_W-1:0]   preg;
   logic [NRD-1:0][DW-1:0]       raw;
   logic [NRD-1:0][PH_W-1:0]     ridx;
   logic                         we_eff;

   assign lreg[0] = rd_a_addr_i;
   assign lreg[1] = rd_b_addr_i;
   assign lreg[2] = wr_addr_i;

   rwin_ctrl #(.N_WIN(N_WIN), .CW_W(CW_W)) ctrl_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .call_i(call_i),
      .ret_i (ret_i),
      .cwp_o (cwp_o),
      .ovf_o (ovf_o),
      .unf_o (unf_o)
   );

   for (genvar g = 0; g < NPORT; g++) begin : g_map
      rwin_map #(
         .N_GLOB (N_GLOB),
         .N_LOCAL(N_LOCAL),
         .N_SHARE(N_SHARE),
         .N_WIN  (N_WIN),
         .CW_W   (CW_W),
         .PH_W   (PH_W)
      ) map_i (
         .cwp_i (cwp_o),
         .lreg_i(lreg[g]),
         .preg_o(preg[g])
      );
   end

   for (genvar p = 0; p < NRD; p++) begin : g_ridx
      assign ridx[p] = preg[p];
   end

   // writes to logical 0 never reach the array
   assign we_eff = wr_en_i && (wr_addr_i != '0);

   rwin_store #(
      .DW         (DW),
      .NPHYS      (NPHYS),
      .NRD        (NRD),
      .WRITE_FIRST(WRITE_FIRST),
      .PH_W       (PH_W)
   ) store_i (
      .clk_i  (clk_i),
      .we_i   (we_eff),
      .widx_i (preg[NPORT-1]),
      .wdata_i(wr_data_i),
      .ridx_i (ridx),
      .rdata_o(raw)
   );

   assign rd_a_data_o = (rd_a_addr_i == '0) ? '0 : raw[0];
   assign rd_b_data_o = (rd_b_addr_i == '0) ? '0 : raw[1];

   p_zero_rd_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));
   p_bypass_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (WRITE_FIRST && wr_en_i && wr_addr_i != '0 && wr_addr_i == rd_b_addr_i)
         |-> (rd_b_data_o == wr_data_i));
   p_port_agree_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_a_addr_i == rd_b_addr_i) |-> (rd_a_data_o == rd_b_data_o));
endmodule

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb_top;
   localparam int NPHYS = 138;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        call = 1'b0, ret = 1'b0, we = 1'b0;
   logic [4:0]  ra = '0, rb = '0, wa = '0;
   logic [31:0] wd = '0;
   logic [31:0] rda, rdb;
   logic [2:0]  cwp;
   logic        ovf, unf;

   int total = 0, bad = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_mem [NPHYS];
   bit          m_ok  [NPHYS];
   int          m_cwp = 0, m_dep = 0;
   logic [31:0] last_a;

   always #2 clk = ~clk;   // 250 MHz

   rwin_regfile dut_i (
      .clk_i(clk), .rst_i(rst), .call_i(call), .ret_i(ret),
      .rd_a_addr_i(ra), .rd_a_data_o(rda),
      .rd_b_addr_i(rb), .rd_b_data_o(rdb),
      .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
      .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
   );

   function automatic int phys(input int w, input int lr);
      int off;
      if (lr < 10) return lr;
      off = (lr < 26) ? lr - 10 : lr - 26 + 16;
      return 10 + (w * 16 + off) % 128;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic chk_rd(input int lr, input logic [31:0] got);
      int pi;
      pi = phys(m_cwp, lr);
      if (lr == 0) chk("R2", got, 32'h0);
      else if (we && wa != 0 && phys(m_cwp, int'(wa)) == pi) chk("R10", got, wd);
      else if (m_ok[pi]) begin
         if (lr < 10) chk("R3", got, m_mem[pi]);
         else if (lr < 16) chk("R4", got, m_mem[pi]);
         else chk("R11", got, m_mem[pi]);
      end
   endtask

   task automatic step(input bit c, input bit r, input bit w, input int a,
                       input logic [31:0] d, input int x, input int y);
      bit eo, eu;
      @(negedge clk);
      call = c; ret = r; we = w; wa = 5'(a); wd = d; ra = 5'(x); rb = 5'(y);
      #1;
      chk("R6", 32'(cwp), 32'(m_cwp));
      eo = c && !r && m_dep == 7;
      eu = r && !c && m_dep == 0;
      chk((c && r) ? "R9" : "R7", 32'(ovf), 32'(eo));
      chk((c && r) ? "R9" : "R8", 32'(unf), 32'(eu));
      chk_rd(x, rda);
      chk_rd(y, rdb);
      last_a = rda;
      @(posedge clk);
      if (w && a != 0) begin
         m_mem[phys(m_cwp, a)] = d;
         m_ok[phys(m_cwp, a)]  = 1;
      end
      if (c && !r) begin
         m_cwp = (m_cwp + 1) % 8;
         if (m_dep < 7) m_dep++;
      end else if (r && !c) begin
         m_cwp = (m_cwp + 7) % 8;
         if (m_dep > 0) m_dep--;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; call = 0; ret = 0; we = 0;
      @(posedge clk);
      @(posedge clk);
      #1;
      rst = 0;
      m_cwp = 0; m_dep = 0;
   endtask

   initial begin
      for (int i = 0; i < NPHYS; i++) m_ok[i] = 0;
      void'($urandom(32'h5eed_0042));
      do_reset();
      // R1: pointer starts at 0, return at depth 0 underflows
      #1;
      chk("R1", 32'(cwp), 32'd0);
      @(negedge clk);
      ret = 1; #1;
      chk("R1", 32'(unf), 32'd1);
      ret = 0;
      do_reset();

      // R2: write to logical 0 ignored
      step(0, 0, 1, 0, 32'hdead_beef, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R2", rda, 32'h0);
      // R3: global visible in the next window
      step(0, 0, 1, 5, 32'h0000_0505, 0, 0);
      step(1, 0, 0, 0, 0, 5, 0);
      step(0, 0, 0, 0, 0, 5, 0);
      chk("R3", last_a, 32'h0000_0505);
      // R4: outgoing 28 of window 1 is incoming 12 of window 2
      step(0, 0, 1, 28, 32'h2812_0001, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 12, 0);
      chk("R4", last_a, 32'h2812_0001);
      // R5: locals are private
      step(0, 0, 1, 20, 32'haaaa_0020, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 20, 32'hbbbb_0020, 0, 0);
      step(0, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 20, 0);
      chk("R5", last_a, 32'haaaa_0020);
      // R9: call and return together
      step(1, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R9", 32'(cwp), 32'd2);
      // R10: write-first
      step(0, 0, 1, 17, 32'h1717_1717, 17, 17);
      chk("R10", last_a, 32'h1717_1717);
      // R7 / R12: climb to window 7, then wrap into window 0
      for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 27, 32'h7007_0027, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);   // model flags overflow here
      step(0, 0, 0, 0, 0, 11, 0);
      chk("R12", last_a, 32'h7007_0027);
      chk("R12", 32'(cwp), 32'd0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int rc, rr;
         rc = $urandom_range(7);
         rr = $urandom_range(7);
         step(rc == 0, rr == 0, $urandom_range(1) == 1, $urandom_range(31),
              $urandom(), $urandom_range(31), $urandom_range(31));
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule